// File: doc/BRIEF.md
# Banked Memory-Mapped Interrupt Controller

This block gathers interrupt sources in groups of thirty-two, called banks, and presents them to a processor through a small 32-bit register bus. Every bank has four word registers: a latched event word, an enable word, a write-one-to-clear acknowledge word and a read-only word that mirrors the synchronized input lines. A constant mask per bank marks which sources are level-sensitive. The rest are edge-sensitive.

An enabled source latches its event bit on a rising edge of its synchronized input. The single request line to the processor is raised by enabled, latched events only. Turning on an enable bit while the input is already high therefore latches nothing and raises no request. Software has to poll or retrigger such a source itself. A separate read-only index output reports the highest-numbered pending source. For this index, level sources are taken from their live input and edge sources from their latched event bit, and both are qualified by enable.

Registers use little-endian bit numbering: bit i of a bank word belongs to source bank*32+i. Each bank occupies 16 bytes. The word offsets within a bank are event 0x0, enable 0x4, acknowledge 0x8 and input mirror 0xC. Bank b starts at byte address b*0x10.

Top module: `irqc_top`

## Requirements
- R1: After reset all event and enable bits are 0, `irq_o` is 0 and `top_idx_o` is all ones (127 for two banks).
- R2: An enabled source whose synchronized input rises sets its event bit (offset 0x0, bit = source mod 32). For an edge source with its enable on, `irq_o` goes to 1.
- R3: Writing the acknowledge word (offset 0x8) clears each event bit written as 1 and leaves bits written as 0 unchanged.
- R4: When a rising edge and an acknowledge of the same bit fall in the same cycle, the event bit ends up set.
- R5: The input-mirror word (offset 0xC) reads back the synchronized state of all 32 inputs of the bank, whether they are enabled or not.
- R6: Setting an enable bit while that source's input is already high sets no event bit and does not assert `irq_o`.
- R7: A level source counts as pending while its input is high and enabled, and stops counting once the input falls. An edge source counts as pending only while its event bit is set and it is enabled. With the default parameters, bank 0 level sources are bits 20..29 (mask 0x3FF00000) and bank 1 level sources are bits 20..28 (mask 0x1FF00000).
- R8: `top_idx_o` gives the highest-numbered pending source. A pending source in bank 1 wins over any source in bank 0. When nothing is pending the output is all ones.
- R9: A written enable word reads back unchanged. The acknowledge word always reads 0.
- R10: Bank b sits at byte base b*0x10. Reads from addresses beyond the last bank return 0, and writes to those addresses change nothing.
- R11: A rising edge that arrives while its enable bit is 0 is not latched.
- R12: `irq_o` is the OR over all banks of (event AND enable). Clearing enable drops the request and keeps the event bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_BANKS*32 | Asynchronous interrupt source lines |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe; data appears on the following cycle |
| bus_rdata_o | output | 32 | Read data, held until the next read |
| irq_o | output | 1 | Interrupt request to the processor |
| top_idx_o | output | $clog2(NUM_BANKS*32)+1 | Highest pending source, all ones if none |

## Verification
Some behaviours are checked by the assertions on every cycle. These are: acknowledge clearing event bits, an enabled rise winning over a simultaneous acknowledge, new event bits appearing only on enabled high inputs, a request never being present with all enables clear, and the index always naming the top pending bit or reading all ones. Other behaviours can only be shown by the bench's scenarios. These are the address map and its out-of-range holes, enable readback, and the mirror word. They also include the split between level sources (live input) and edge sources (latched), the quirk where an enable lands on an already-high input, and the ordering of banks in the index.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W = 32;

    // Word index inside a bank (byte address bits [3:2])
    localparam logic [1:0] W_EVENT  = 2'd0;
    localparam logic [1:0] W_ENABLE = 2'd1;
    localparam logic [1:0] W_ACK    = 2'd2;
    localparam logic [1:0] W_MIRROR = 2'd3;

    typedef struct packed {
        logic [BANK_W-1:0] evt;
        logic [BANK_W-1:0] ena;
        logic [BANK_W-1:0] prev;
    } bank_st_t;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst_i) stg_q[i] <= '0;
            else       stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] LVL_MASK = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [BANK_W-1:0] src_s_i,
    input  logic              ena_we_i,
    input  logic              ack_we_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] evt_o,
    output logic [BANK_W-1:0] ena_o,
    output logic [BANK_W-1:0] pend_o,
    output logic [BANK_W-1:0] set_o,
    output logic [BANK_W-1:0] ack_o
);

    bank_st_t st_d, st_q;
    logic [BANK_W-1:0] rise_d;
    logic [BANK_W-1:0] set_d;
    logic [BANK_W-1:0] ack_d;

    always_comb begin
        st_d   = st_q;
        ack_d  = ack_we_i ? wdata_i : '0;
        rise_d = src_s_i & ~st_q.prev;
        // A new edge only counts for a source already enabled
        set_d  = rise_d & st_q.ena;
        // Setting has priority over a same-cycle acknowledge
        st_d.evt  = (st_q.evt & ~ack_d) | set_d;
        st_d.prev = src_s_i;
        if (ena_we_i) begin
            st_d.ena = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign evt_o  = st_q.evt;
    assign ena_o  = st_q.ena;
    assign set_o  = set_d;
    assign ack_o  = ack_d;
    // Level sources from the live line, edge sources from the latch
    assign pend_o = ((st_q.evt & ~LVL_MASK) | (src_s_i & LVL_MASK)) & st_q.ena;

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int W     = 32,
    localparam int IX_W = $clog2(W)
) (
    input  logic [W-1:0]    vec_i,
    output logic            any_o,
    output logic [IX_W-1:0] idx_o
);

    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) idx_o = IX_W'(i);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = {32'h1FF0_0000, 32'h3FF0_0000},
    localparam int NUM_SRC = NUM_BANKS * BANK_W,
    localparam int IDX_W   = $clog2(NUM_SRC) + 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [BANK_W-1:0]  bus_wdata_i,
    input  logic               bus_rd_i,
    output logic [BANK_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   top_idx_o
);

    localparam int BSEL_W = ADDR_W - 4;
    localparam int BIX_W  = $clog2(BANK_W);

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic [BSEL_W-1:0] bank_sel;
    logic [1:0]        word_sel;
    logic              unused_addr_lsb;

    logic [NUM_SRC-1:0] src_s;
    logic [NUM_SRC-1:0] evt_all;
    logic [NUM_SRC-1:0] ena_all;
    logic [NUM_SRC-1:0] pend_all;
    logic [NUM_SRC-1:0] set_all;
    logic [NUM_SRC-1:0] ack_all;
    logic [NUM_BANKS-1:0] bank_any;
    logic [BIX_W-1:0]     bank_idx [NUM_BANKS];

    assign bank_sel        = bus_addr_i[ADDR_W-1:4];
    assign word_sel        = bus_addr_i[3:2];
    assign unused_addr_lsb = ^bus_addr_i[1:0];

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (src_i),
        .q_o   (src_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank_sel == BSEL_W'(b));

        irqc_bank #(.LVL_MASK(LEVEL_MASK[b*BANK_W +: BANK_W])) u_bank (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .src_s_i  (src_s[b*BANK_W +: BANK_W]),
            .ena_we_i (bus_wr_i && hit && (word_sel == W_ENABLE)),
            .ack_we_i (bus_wr_i && hit && (word_sel == W_ACK)),
            .wdata_i  (bus_wdata_i),
            .evt_o    (evt_all[b*BANK_W +: BANK_W]),
            .ena_o    (ena_all[b*BANK_W +: BANK_W]),
            .pend_o   (pend_all[b*BANK_W +: BANK_W]),
            .set_o    (set_all[b*BANK_W +: BANK_W]),
            .ack_o    (ack_all[b*BANK_W +: BANK_W])
        );

        irqc_prio #(.W(BANK_W)) u_prio (
            .vec_i (pend_all[b*BANK_W +: BANK_W]),
            .any_o (bank_any[b]),
            .idx_o (bank_idx[b])
        );
    end

    // Read path: one registered word, held between reads
    always_comb begin
        st_d = st_q;
        if (bus_rd_i) begin
            st_d.rdata = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_sel == BSEL_W'(b)) begin
                    case (word_sel)
                        W_EVENT:  st_d.rdata = evt_all[b*BANK_W +: BANK_W];
                        W_ENABLE: st_d.rdata = ena_all[b*BANK_W +: BANK_W];
                        W_MIRROR: st_d.rdata = src_s[b*BANK_W +: BANK_W];
                        default:  st_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    // Highest bank with anything pending, then its highest bit
    always_comb begin
        top_idx_o = '1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_any[b]) top_idx_o = IDX_W'(b * BANK_W + int'(bank_idx[b]));
        end
    end

    assign irq_o       = |(evt_all & ena_all);
    assign bus_rdata_o = st_q.rdata;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 7
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               irq_i,
    input logic [IDX_W-1:0]   idx_i,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [NUM_SRC-1:0] ena_i,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] set_i,
    input logic [NUM_SRC-1:0] ack_i,
    input logic [NUM_SRC-1:0] src_s_i
);

    assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((evt_i & $past(ack_i & ~set_i)) == '0));

    assert_set_beats_ack_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((evt_i & $past(set_i)) == $past(set_i)));

    assert_event_needs_enabled_input_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((evt_i & ~$past(evt_i) & ~($past(ena_i) & $past(src_s_i))) == '0));

    assert_request_needs_enable_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_i |-> (ena_i != '0));

    assert_idle_index_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_i == '0) |-> (&idx_i));

    assert_index_highest_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_i != '0) |-> ((pend_i >> idx_i[IDX_W-2:0]) == NUM_SRC'(1)));

endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .irq_i   (irq_o),
    .idx_i   (top_idx_o),
    .evt_i   (evt_all),
    .ena_i   (ena_all),
    .pend_i  (pend_all),
    .set_i   (set_all),
    .ack_i   (ack_all),
    .src_s_i (src_s)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic [6:0]  idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .top_idx_o   (idx)
    );

    typedef struct packed {
        logic        is_rd;
        logic [5:0]  a;
        logic [31:0] d;
    } vec_t;

    // Register map walk (R9, R10)
    localparam vec_t VECS [12] = '{
        '{1'b0, 6'h04, 32'h0000_00FF},
        '{1'b1, 6'h04, 32'h0000_00FF},
        '{1'b0, 6'h14, 32'hA5A5_0000},
        '{1'b1, 6'h14, 32'hA5A5_0000},
        '{1'b1, 6'h08, 32'h0000_0000},
        '{1'b1, 6'h18, 32'h0000_0000},
        '{1'b0, 6'h24, 32'h0000_FFFF},
        '{1'b1, 6'h24, 32'h0000_0000},
        '{1'b1, 6'h3C, 32'h0000_0000},
        '{1'b1, 6'h04, 32'h0000_00FF},
        '{1'b0, 6'h04, 32'h0000_0000},
        '{1'b0, 6'h14, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src = v;
        wait_cyc(4);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 idx", 32'(idx), 32'd127);
        bus_read(6'h00, v); check("R1 event0", v, 32'h0);
        bus_read(6'h14, v); check("R1 enable1", v, 32'h0);

        // R9 / R10 vector walk
        foreach (VECS[k]) begin
            if (VECS[k].is_rd) begin
                bus_read(VECS[k].a, v);
                check($sformatf("R9_R10 vec %0d", k), v, VECS[k].d);
            end else begin
                bus_write(VECS[k].a, VECS[k].d);
            end
        end

        // R2 enabled edge latches and requests
        bus_write(6'h04, 32'h8);
        src[3] = 1'b1; set_src(src);
        bus_read(6'h00, v); check("R2 event", v, 32'h8);
        check("R2 irq", 32'(irq), 32'h1);
        check("R2 idx", 32'(idx), 32'd3);

        // R3 acknowledge is write-one-to-clear
        bus_write(6'h08, 32'h4);
        bus_read(6'h00, v); check("R3 zero bits kept", v, 32'h8);
        bus_write(6'h08, 32'h8);
        bus_read(6'h00, v); check("R3 cleared", v, 32'h0);
        check("R3 irq", 32'(irq), 32'h0);
        check("R7 edge input high, no latch", 32'(idx), 32'd127);

        // R11 edge while disabled, then R6 enable on a high line
        src[5] = 1'b1; set_src(src);
        bus_read(6'h00, v); check("R11 no latch", v, 32'h0);
        bus_write(6'h04, 32'h28);
        wait_cyc(4);
        bus_read(6'h00, v); check("R6 edge event", v, 32'h0);
        check("R6 edge irq", 32'(irq), 32'h0);

        // R6 / R7 / R5 level source
        src[21] = 1'b1; set_src(src);
        bus_write(6'h04, 32'h0020_0028);
        wait_cyc(2);
        check("R6 level irq", 32'(irq), 32'h0);
        bus_read(6'h00, v); check("R6 level event", v, 32'h0);
        check("R7 level pending", 32'(idx), 32'd21);
        bus_read(6'h0C, v); check("R5 mirror0", v, 32'h0020_0028);
        src[21] = 1'b0; set_src(src);
        check("R7 level drop", 32'(idx), 32'd127);

        // R8 bank ordering
        set_src('0);
        bus_write(6'h04, 32'h18);
        bus_write(6'h14, 32'h0010_0010);
        src[3] = 1'b1; src[4] = 1'b1; set_src(src);
        check("R8 bank0 top bit", 32'(idx), 32'd4);
        src[36] = 1'b1; set_src(src);
        check("R8 bank1 wins", 32'(idx), 32'd36);
        src[52] = 1'b1; set_src(src);
        check("R8 level bank1", 32'(idx), 32'd52);
        src[52] = 1'b0; set_src(src);
        check("R7 bank1 level drop", 32'(idx), 32'd36);
        bus_read(6'h1C, v); check("R5 mirror1", v, 32'h10);
        bus_write(6'h18, 32'h10);
        check("R8 back to bank0", 32'(idx), 32'd4);

        // R12 disabling drops the request, keeps events
        check("R12 irq before", 32'(irq), 32'h1);
        bus_write(6'h04, 32'h0);
        bus_write(6'h14, 32'h0);
        check("R12 irq after", 32'(irq), 32'h0);
        bus_read(6'h00, v); check("R12 events kept", v, 32'h18);
        check("R8 idle idx", 32'(idx), 32'd127);

        // R4 rise and acknowledge in the same cycle
        bus_write(6'h04, 32'h80);
        @(negedge clk); src[7] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 6'h08; wdata = 32'h80; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        wait_cyc(2);
        bus_read(6'h00, v); check("R4 set wins", v, 32'h98);
        check("R4 irq", 32'(irq), 32'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule